// File: doc/BRIEF.md
# Configurable Line Fault Injector

This block sits on an N-line data stream between a producer and a circuit under test and corrupts the stream with at most one modelled defect at a time. The defect is chosen through a small configuration port: a fault code, a target line and, for bridge defects, a partner line. The supported defects are stuck-at-0, stuck-at-1, symmetric wired-AND and wired-OR bridges, and three dominant bridge forms. Shorts to supply or ground use the stuck-at codes, because they behave the same way.

The configuration is held in registers that load only on a strobe, so the active defect cannot change in the middle of a vector. The data path is purely combinational and adds no latency. The stream uses a valid/ready handshake that passes straight through: `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. Back-pressure from the circuit under test therefore reaches the producer at once, and nothing is buffered. A bridge request between lines that are not adjacent, or that names a line outside the bus, is refused. A refused request leaves no fault active and sets a sticky error flag.

Top module: `fault_injector`

## Requirements
- R1: With fault code 0 (none) loaded, or with the enable bit clear in the last accepted configuration, `out_data` equals `in_data` bit for bit in the same cycle.
- R2: Code 1 forces the target line to 0 and code 2 forces it to 1, whatever its input value. Every other line passes through unchanged.
- R3: Code 3 (wired-AND) drives both the target line and the partner line to the AND of their two input values. Code 4 (wired-OR) does the same with OR.
- R4: Code 5 (dominant) makes the target line, the victim, take the value of the partner line, the aggressor. The partner line is unchanged.
- R5: Code 6 drives the target line to its own value ANDed with the partner's value, and code 7 does the same with OR. The partner line is unchanged in both cases.
- R6: A bridge request (codes 3 to 7) is refused when the partner index is not target±1, or when either index is at or above LINES. A refused request sets `config_error` and leaves no fault active.
- R7: The configuration fields are sampled only on a clock edge at which `cfg_valid` is 1, and take effect from the next cycle. Changes to the fields while `cfg_valid` is 0 have no effect.
- R8: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle. While `out_ready` is 0, `in_ready` is 0 and the vector is held by the producer.
- R9: A stuck-at request (code 1 or 2) whose target index is at or above LINES is refused in the same way as in R6.
- R10: `config_error` is 0 after reset. Once set, it stays at 1 until reset, even after later configurations are accepted.
- R11: At most two lines are corrupted at any time, and a line outside the fault's target/partner set always equals its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration load strobe |
| cfg_enable | input | 1 | 1 arms the requested fault; 0 requests bypass |
| cfg_type | input | 3 | Fault code: 0 none, 1 stuck-0, 2 stuck-1, 3 wired-AND, 4 wired-OR, 5 dominant, 6 dominant-AND, 7 dominant-OR |
| cfg_target | input | clog2(LINES) | Target (victim) line index |
| cfg_partner | input | clog2(LINES) | Partner (aggressor) line index for bridges |
| config_error | output | 1 | Sticky flag for a refused configuration |
| in_valid | input | 1 | Producer has a vector |
| in_ready | output | 1 | Vector is taken this cycle |
| in_data | input | LINES | Fault-free vector |
| out_valid | output | 1 | Corrupted vector is presented |
| out_ready | input | 1 | Circuit under test accepts the vector |
| out_data | output | LINES | Vector with the active fault applied |

## Verification
The assertions assume three things about the inputs: reset is applied before the first strobe, the configuration fields are meaningful only when the strobe is high, and the stream handshake is driven by the producer and consumer alone. The stimulus drives all inputs one nanosecond after a rising edge. It changes the configuration only in cycles where no vector is offered, so each expected vector belongs to exactly one configuration. The stimulus deliberately wiggles the configuration fields with the strobe low, and holds `out_ready` low while a vector waits, to exercise the hold and back-pressure rules.

// File: rtl/fi_pkg.sv
`timescale 1ns/1ps
package fi_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_SA0  = 3'd1,
    FLT_SA1  = 3'd2,
    FLT_WAND = 3'd3,
    FLT_WOR  = 3'd4,
    FLT_DOM  = 3'd5,
    FLT_DAND = 3'd6,
    FLT_DOR  = 3'd7
  } fault_e;

  function automatic logic is_bridge(fault_e f);
    return f inside {FLT_WAND, FLT_WOR, FLT_DOM, FLT_DAND, FLT_DOR};
  endfunction

  function automatic logic is_symmetric(fault_e f);
    return f inside {FLT_WAND, FLT_WOR};
  endfunction
endpackage

// File: rtl/fi_cfg_check.sv
`timescale 1ns/1ps
module fi_cfg_check
  import fi_pkg::*;
#(
  parameter int LINES = 12,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  fault_e        ftype,
  input  logic [IW-1:0] tgt,
  input  logic [IW-1:0] ptr,
  output logic          ok
);
  localparam logic [IW:0] LIMIT = (IW+1)'(LINES);

  logic [IW:0] t_ext, p_ext;
  logic        tgt_in, ptr_in, adjacent;

  always_comb begin
    t_ext    = {1'b0, tgt};
    p_ext    = {1'b0, ptr};
    tgt_in   = t_ext < LIMIT;
    ptr_in   = p_ext < LIMIT;
    adjacent = (t_ext == p_ext + 1'b1) || (p_ext == t_ext + 1'b1);
    if (ftype == FLT_NONE)    ok = 1'b1;
    else if (is_bridge(ftype)) ok = tgt_in && ptr_in && adjacent;
    else                      ok = tgt_in;
  end
endmodule

// File: rtl/fi_line_sel.sv
`timescale 1ns/1ps
module fi_line_sel
  import fi_pkg::*;
#(
  parameter int LINES = 12,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  fault_e          ftype,
  input  logic [IW-1:0]   tgt,
  input  logic [IW-1:0]   ptr,
  output logic [LINES-1:0] mask
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_comb begin
      mask[i] = 1'b0;
      if (ftype != FLT_NONE) begin
        if (tgt == IW'(i)) mask[i] = 1'b1;
        if (is_symmetric(ftype) && ptr == IW'(i)) mask[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fi_cfg_regs.sv
`timescale 1ns/1ps
module fi_cfg_regs
  import fi_pkg::*;
#(
  parameter int LINES = 12,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_enable,
  input  fault_e           ftype_in,
  input  logic [IW-1:0]    tgt_in,
  input  logic [IW-1:0]    ptr_in,
  input  logic             req_ok,
  input  logic [LINES-1:0] mask_in,
  output fault_e           ftype_q,
  output logic [IW-1:0]    tgt_q,
  output logic [IW-1:0]    ptr_q,
  output logic [LINES-1:0] mask_q,
  output logic             err_q
);
  logic armed_req;
  assign armed_req = cfg_enable && (ftype_in != FLT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftype_q <= FLT_NONE;
      tgt_q   <= '0;
      ptr_q   <= '0;
      mask_q  <= '0;
      err_q   <= 1'b0;
    end else if (cfg_valid) begin
      if (armed_req && req_ok) begin
        ftype_q <= ftype_in;
        tgt_q   <= tgt_in;
        ptr_q   <= ptr_in;
        mask_q  <= mask_in;
      end else begin
        ftype_q <= FLT_NONE;
        tgt_q   <= '0;
        ptr_q   <= '0;
        mask_q  <= '0;
        if (armed_req) err_q <= 1'b1;
      end
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> ($stable(mask_q) && $stable(ftype_q) && $stable(err_q)));

  // R6
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && armed_req && !req_ok) |=> (mask_q == '0 && err_q));

  // R11
  two_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_q) <= 2);
endmodule

// File: rtl/fi_corrupt.sv
`timescale 1ns/1ps
module fi_corrupt
  import fi_pkg::*;
#(
  parameter int LINES = 12,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fault_e           ftype,
  input  logic [IW-1:0]    tgt,
  input  logic [IW-1:0]    ptr,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  logic tgt_bit, ptr_bit, fault_val;

  always_comb begin
    tgt_bit = 1'b0;
    ptr_bit = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (tgt == IW'(i)) tgt_bit = din[i];
      if (ptr == IW'(i)) ptr_bit = din[i];
    end
  end

  always_comb begin
    unique case (ftype)
      FLT_SA1:            fault_val = 1'b1;
      FLT_WAND, FLT_DAND: fault_val = tgt_bit & ptr_bit;
      FLT_WOR,  FLT_DOR:  fault_val = tgt_bit | ptr_bit;
      FLT_DOM:            fault_val = ptr_bit;
      default:            fault_val = 1'b0;
    endcase
  end

  for (genvar i = 0; i < LINES; i++) begin : g_out
    assign dout[i] = mask[i] ? fault_val : din[i];

    // R11
    untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask[i] |-> (dout[i] == din[i]));
  end

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ftype == FLT_NONE) |-> (dout == din));
endmodule

// File: rtl/fault_injector.sv
`timescale 1ns/1ps
module fault_injector
  import fi_pkg::*;
#(
  parameter int LINES = 12,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_enable,
  input  logic [2:0]       cfg_type,
  input  logic [IW-1:0]    cfg_target,
  input  logic [IW-1:0]    cfg_partner,
  output logic             config_error,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LINES-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LINES-1:0] out_data
);
  fault_e           req_type, act_type;
  logic             req_ok;
  logic [LINES-1:0] req_mask, act_mask;
  logic [IW-1:0]    act_tgt, act_ptr;

  assign req_type = fault_e'(cfg_type);

  fi_cfg_check #(.LINES(LINES)) u_check (
    .ftype(req_type), .tgt(cfg_target), .ptr(cfg_partner), .ok(req_ok)
  );

  fi_line_sel #(.LINES(LINES)) u_sel (
    .ftype(req_type), .tgt(cfg_target), .ptr(cfg_partner), .mask(req_mask)
  );

  fi_cfg_regs #(.LINES(LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_enable(cfg_enable),
    .ftype_in(req_type), .tgt_in(cfg_target), .ptr_in(cfg_partner),
    .req_ok(req_ok), .mask_in(req_mask),
    .ftype_q(act_type), .tgt_q(act_tgt), .ptr_q(act_ptr),
    .mask_q(act_mask), .err_q(config_error)
  );

  fi_corrupt #(.LINES(LINES)) u_corrupt (
    .clk(clk), .rst_n(rst_n), .ftype(act_type), .tgt(act_tgt), .ptr(act_ptr),
    .mask(act_mask), .din(in_data), .dout(out_data)
  );

  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  // R8
  handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));
endmodule

// File: tb/tb_fault_injector.sv
`timescale 1ns/1ps
module tb_fault_injector;
  localparam int N  = 12;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid = 1'b0, cfg_enable = 1'b0;
  logic [2:0]    cfg_type = '0;
  logic [IW-1:0] cfg_target = '0, cfg_partner = '0;
  logic          config_error;
  logic          in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [N-1:0]  in_data = '0, out_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  // bench copy of the accepted configuration
  int  m_type = 0, m_t = 0, m_p = 0;
  bit  m_err = 0;

  always #2.5 clk = ~clk;

  fault_injector #(.LINES(N)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_enable(cfg_enable),
    .cfg_type(cfg_type), .cfg_target(cfg_target), .cfg_partner(cfg_partner),
    .config_error(config_error), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(logic [N-1:0] d);
    logic [N-1:0] r = d;
    logic a, b;
    a = d[m_t];
    b = d[m_p];
    case (m_type)
      1: r[m_t] = 1'b0;
      2: r[m_t] = 1'b1;
      3: begin r[m_t] = a & b; r[m_p] = a & b; end
      4: begin r[m_t] = a | b; r[m_p] = a | b; end
      5: r[m_t] = b;
      6: r[m_t] = a & b;
      7: r[m_t] = a | b;
      default: ;
    endcase
    return r;
  endfunction

  task automatic configure(bit en, int ty, int t, int p);
    bit legal;
    @(posedge clk); #1;
    cfg_valid = 1'b1; cfg_enable = en; cfg_type = 3'(ty);
    cfg_target = IW'(t); cfg_partner = IW'(p);
    @(posedge clk); #1;
    cfg_valid = 1'b0;
    if (ty >= 3) legal = (t < N) && (p < N) && ((t == p + 1) || (p == t + 1));
    else         legal = (t < N);
    if (!en || ty == 0) m_type = 0;
    else if (legal) begin m_type = ty; m_t = t; m_p = p; end
    else begin m_type = 0; m_err = 1; end
  endtask

  task automatic send(logic [N-1:0] d, string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d;
    exp_q.push_back(model(d));
    tag_q.push_back(tag);
    @(negedge clk);
    while (!out_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected vector", out_data, '0);
      else begin
        logic [N-1:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(out_data == e, tg, out_data, e);
      end
    end
  end

  task automatic check_err(string tag);
    @(negedge clk);
    check(config_error == m_err, tag, N'(config_error), N'(m_err));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(config_error == 1'b0, "R10 reset error flag", N'(config_error), '0);

    // R1 bypass paths
    send(12'hA5C, "R1 none after reset");
    configure(1'b0, 2, 3, 0);
    send(12'h000, "R1 enable clear ignores stuck-1");
    send(12'hFFF, "R1 enable clear all ones");

    // R2 stuck-at
    configure(1'b1, 1, 5, 0);
    send(12'hFFF, "R2 stuck-0 line 5");
    send(12'h3C1, "R2 stuck-0 others untouched");
    configure(1'b1, 2, 11, 0);
    send(12'h000, "R2 stuck-1 line 11");

    // R3 symmetric bridges
    configure(1'b1, 3, 2, 3);
    send(12'h004, "R3 wired-AND 2/3");
    send(12'h00C, "R3 wired-AND both high");
    configure(1'b1, 4, 7, 6);
    send(12'h040, "R3 wired-OR 7/6");

    // R4 dominant
    configure(1'b1, 5, 4, 5);
    send(12'h020, "R4 dominant victim 4 takes 1");
    send(12'h010, "R4 dominant victim 4 takes 0");

    // R5 dominant-AND / dominant-OR
    configure(1'b1, 6, 9, 8);
    send(12'h200, "R5 dominant-AND victim high");
    send(12'h100, "R5 dominant-AND aggressor kept");
    configure(1'b1, 7, 0, 1);
    send(12'h002, "R5 dominant-OR 0/1");
    send(12'h001, "R5 dominant-OR aggressor kept");

    // R6 illegal bridges
    configure(1'b1, 3, 2, 5);
    check_err("R6 non-adjacent sets error");
    send(12'h004, "R6 non-adjacent no fault");
    configure(1'b1, 4, 11, 12);
    send(12'h800, "R6 partner out of range no fault");

    // R10 sticky after a good config
    configure(1'b1, 1, 0, 0);
    check_err("R10 error stays set");
    send(12'h001, "R10 good config applies after error");

    // R9 stuck target out of range
    configure(1'b1, 2, 13, 0);
    send(12'h000, "R9 stuck target out of range no fault");

    // R7 fields ignored without strobe
    configure(1'b1, 2, 1, 0);
    @(posedge clk); #1;
    cfg_type = 3'd1; cfg_target = 4'd2; cfg_enable = 1'b1;
    send(12'h004, "R7 unstrobed fields ignored");

    // R8 back-pressure
    @(posedge clk); #1;
    out_ready = 1'b0; in_valid = 1'b1; in_data = 12'h0F0;
    exp_q.push_back(model(12'h0F0));
    tag_q.push_back("R8 held vector delivered");
    repeat (3) begin
      @(negedge clk);
      check(in_ready == 1'b0 && out_valid == 1'b1, "R8 back-pressure",
            N'({in_ready, out_valid}), N'(2'b01));
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R8 ready follows", N'(in_ready), N'(1));
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid follows", N'(out_valid), '0);

    repeat (2) @(posedge clk);
    check(exp_q.size() == 0, "R8 scoreboard drained", N'(exp_q.size()), '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule